// File: doc/BRIEF.md
# Exception Entry Dispatcher

This block is the exception-entry stage of a small 32-bit processor core. Each cycle it looks at two request channels. The synchronous-fault channel carries the faulting PC, a cause code and an optional faulting virtual address. The debug channel carries a PC and a debug cause. The block decides whether one of them is taken and which entry vector applies: kernel, user, double or debug. In the same clock edge it commits every special-register update that the entry requires.

The special registers form a small register file. It holds the status word, the cause, the faulting address, the double-fault PC, the debug cause, one saved PC per interrupt level and one saved status per level from 2 upward. Software moves reach the file through a single write port. A combinational read port exposes any entry. A one-cycle redirect strobe and a registered vector identifier tell the fetch logic where to go. The vector addresses themselves, fetch and pipeline flush are handled elsewhere. The core reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `exc_dispatch`

## Requirements
- R1: When a fault request is taken while status bit 4 (exception mode) is already 1, the entry is a double fault and `vector_o` reads 2.
- R2: On a double fault, the PC goes to the double-fault PC register (index 3) when `HAS_DEPC` is 1. When `HAS_DEPC` is 0 it goes to the level-1 saved PC (index 8), and index 3 is left unchanged.
- R3: On a fault taken with exception mode clear, the PC goes to index 8. `vector_o` reads 1 if status bit 5 (user mode) is 1, and 0 otherwise.
- R4: Every taken fault writes its cause, zero-extended, into the cause register (index 1) and sets status bit 4. All other status bits keep their values.
- R5: A taken fault with `exc_addr_vld_i` high writes `exc_addr_i` into the faulting-address register (index 2). With it low, index 2 keeps its value.
- R6: A debug request is taken only when the status interrupt level (bits 3:0) is below `DBG_LVL`. A refused debug request with no fault request produces no redirect and changes no register.
- R7: A taken debug entry does the following in one commit:
  - it writes the PC to saved PC index 7+`DBG_LVL`;
  - it writes the old status to saved status index 16+`DBG_LVL`;
  - it writes the debug cause to index 4;
  - it replaces status bits 3:0 with `DBG_LVL` and sets bit 4;
  - it reports `vector_o` = 3.
- R8: When a fault request and a takeable debug request arrive in the same cycle, only the debug entry is committed. The cause and faulting-address registers are untouched.
- R9: A software write (`sw_we_i`) to an index below 24 lands in that entry on the next edge. It is discarded entirely in any cycle in which a dispatch commits. The read port returns the addressed entry, or zero for indices 24 and above.
- R10: `redirect_o` is high for exactly the one cycle after each committed entry and low otherwise. `vector_o` changes only with a redirect.
- R11: During reset and after it, every register reads zero and `redirect_o` is low. Requests are honoured from the third rising edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exc_req_i | input | 1 | Synchronous fault request |
| exc_pc_i | input | XLEN | PC of the faulting instruction |
| exc_cause_i | input | CAUSE_W | Fault cause code |
| exc_addr_vld_i | input | 1 | Fault carries a virtual address |
| exc_addr_i | input | XLEN | Faulting virtual address |
| dbg_req_i | input | 1 | Debug entry request |
| dbg_pc_i | input | XLEN | PC saved on debug entry |
| dbg_cause_i | input | DCAUSE_W | Debug cause code |
| sw_we_i | input | 1 | Software move write enable |
| sw_idx_i | input | IDX_W | Software write index |
| sw_wdata_i | input | XLEN | Software write data |
| rd_idx_i | input | IDX_W | Read port index |
| rd_data_o | output | XLEN | Read port data (combinational) |
| redirect_o | output | 1 | One-cycle strobe after a committed entry |
| vector_o | output | 2 | Vector: 0 kernel, 1 user, 2 double, 3 debug |

## Verification
All results of a request, both the register updates and the redirect/vector pair, become visible after the single rising edge that follows the request. The bench drives a request just after a falling edge and lets one rising edge pass. At the next falling edge it compares the strobe and vector, then walks the read port across every entry. It does this for two instances, one with the double-fault PC register and one without, each against its own model. The read port is combinational, so every entry is read inside that same low phase, before the next edge can commit anything else.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  // status word layout
  localparam int ST_ILVL_W   = 4;
  localparam int ST_EXCM_BIT = 4;
  localparam int ST_USER_BIT = 5;

  // special register index map
  localparam int IDX_STATUS   = 0;
  localparam int IDX_CAUSE    = 1;
  localparam int IDX_FADDR    = 2;
  localparam int IDX_DEPC     = 3;
  localparam int IDX_DCAUSE   = 4;
  localparam int IDX_EPC_BASE = 7;   // level L saved PC at 7+L
  localparam int IDX_EPS_BASE = 16;  // level L saved status at 16+L

  // dispatch write ports: status, pc/cause, aux, aux
  localparam int NWP = 4;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 6,
  parameter int DCAUSE_W = 6,
  parameter int DBG_LVL  = 6,
  parameter bit HAS_DEPC = 1'b1,
  parameter int IDX_W    = 5
) (
  input  logic [XLEN-1:0]               status_i,
  input  logic                          exc_req_i,
  input  logic [XLEN-1:0]               exc_pc_i,
  input  logic [CAUSE_W-1:0]            exc_cause_i,
  input  logic                          exc_addr_vld_i,
  input  logic [XLEN-1:0]               exc_addr_i,
  input  logic                          dbg_req_i,
  input  logic [XLEN-1:0]               dbg_pc_i,
  input  logic [DCAUSE_W-1:0]           dbg_cause_i,
  output logic                          commit_o,
  output vec_e                          vec_o,
  output logic [NWP-1:0]                wp_en_o,
  output logic [NWP-1:0][IDX_W-1:0]     wp_idx_o,
  output logic [NWP-1:0][XLEN-1:0]      wp_data_o
);

  localparam logic [ST_ILVL_W-1:0] DBG_L   = ST_ILVL_W'(DBG_LVL);
  localparam logic [IDX_W-1:0] I_STATUS    = IDX_W'(IDX_STATUS);
  localparam logic [IDX_W-1:0] I_CAUSE     = IDX_W'(IDX_CAUSE);
  localparam logic [IDX_W-1:0] I_FADDR     = IDX_W'(IDX_FADDR);
  localparam logic [IDX_W-1:0] I_DCAUSE    = IDX_W'(IDX_DCAUSE);
  localparam logic [IDX_W-1:0] I_EPC1      = IDX_W'(IDX_EPC_BASE + 1);
  localparam logic [IDX_W-1:0] I_EPC_DBG   = IDX_W'(IDX_EPC_BASE + DBG_LVL);
  localparam logic [IDX_W-1:0] I_EPS_DBG   = IDX_W'(IDX_EPS_BASE + DBG_LVL);

  logic [IDX_W-1:0] dbl_idx;
  logic             dbg_go;
  logic             exc_go;
  logic             in_excm;
  logic [XLEN-1:0]  st_dbg;
  logic [XLEN-1:0]  st_exc;

  // variant: where a double-fault PC is saved
  generate
    if (HAS_DEPC) begin : g_depc
      assign dbl_idx = IDX_W'(IDX_DEPC);
    end else begin : g_no_depc
      assign dbl_idx = I_EPC1;
    end
  endgenerate

  assign in_excm  = status_i[ST_EXCM_BIT];
  assign dbg_go   = dbg_req_i && (status_i[ST_ILVL_W-1:0] < DBG_L);
  assign exc_go   = exc_req_i && !dbg_go;
  assign commit_o = dbg_go || exc_go;

  always_comb begin
    st_dbg = status_i;
    st_dbg[ST_ILVL_W-1:0] = DBG_L;
    st_dbg[ST_EXCM_BIT]   = 1'b1;
    st_exc = status_i;
    st_exc[ST_EXCM_BIT]   = 1'b1;
  end

  always_comb begin
    wp_en_o   = '0;
    wp_idx_o  = '0;
    wp_data_o = '0;
    vec_o     = VEC_KERNEL;
    if (dbg_go) begin
      vec_o        = VEC_DEBUG;
      wp_en_o      = '1;
      wp_idx_o[0]  = I_STATUS;
      wp_data_o[0] = st_dbg;
      wp_idx_o[1]  = I_EPC_DBG;
      wp_data_o[1] = dbg_pc_i;
      wp_idx_o[2]  = I_EPS_DBG;
      wp_data_o[2] = status_i;
      wp_idx_o[3]  = I_DCAUSE;
      wp_data_o[3] = {{(XLEN-DCAUSE_W){1'b0}}, dbg_cause_i};
    end else if (exc_go) begin
      if (in_excm) begin
        vec_o = VEC_DOUBLE;
      end else if (status_i[ST_USER_BIT]) begin
        vec_o = VEC_USER;
      end else begin
        vec_o = VEC_KERNEL;
      end
      wp_en_o      = {exc_addr_vld_i, 3'b111};
      wp_idx_o[0]  = I_STATUS;
      wp_data_o[0] = st_exc;
      wp_idx_o[1]  = in_excm ? dbl_idx : I_EPC1;
      wp_data_o[1] = exc_pc_i;
      wp_idx_o[2]  = I_CAUSE;
      wp_data_o[2] = {{(XLEN-CAUSE_W){1'b0}}, exc_cause_i};
      wp_idx_o[3]  = I_FADDR;
      wp_data_o[3] = exc_addr_i;
    end
  end

endmodule

// File: rtl/exc_sreg_file.sv
module exc_sreg_file
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 24,
  parameter int IDX_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit_i,
  input  logic [NWP-1:0]            wp_en_i,
  input  logic [NWP-1:0][IDX_W-1:0] wp_idx_i,
  input  logic [NWP-1:0][XLEN-1:0]  wp_data_i,
  input  logic                      sw_we_i,
  input  logic [IDX_W-1:0]          sw_idx_i,
  input  logic [XLEN-1:0]           sw_wdata_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic [XLEN-1:0]           rd_data_o,
  output logic [XLEN-1:0]           status_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

  logic [XLEN-1:0] regs_q [NREG];
  logic [XLEN-1:0] regs_d [NREG];
  logic            sw_ok;
  logic            upd_en;

  assign sw_ok  = sw_we_i && !commit_i && (sw_idx_i <= LAST);
  assign upd_en = commit_i || sw_ok;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_d[i] = regs_q[i];
    end
    if (sw_ok) begin
      regs_d[sw_idx_i] = sw_wdata_i;
    end
    for (int p = 0; p < NWP; p++) begin
      if (wp_en_i[p]) begin
        regs_d[wp_idx_i[p]] = wp_data_i[p];
      end
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs_q[g] <= '0;
        end else if (upd_en) begin
          regs_q[g] <= regs_d[g];
        end
      end
    end
  endgenerate

  assign rd_data_o = (rd_idx_i <= LAST) ? regs_q[rd_idx_i] : '0;
  assign status_o  = regs_q[IDX_STATUS];

endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 6,
  parameter int DCAUSE_W = 6,
  parameter int NLVL     = 7,
  parameter int DBG_LVL  = 6,
  parameter bit HAS_DEPC = 1'b1,
  localparam int NREG    = IDX_EPS_BASE + NLVL + 1,
  localparam int IDX_W   = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_req_i,
  input  logic [XLEN-1:0]     exc_pc_i,
  input  logic [CAUSE_W-1:0]  exc_cause_i,
  input  logic                exc_addr_vld_i,
  input  logic [XLEN-1:0]     exc_addr_i,
  input  logic                dbg_req_i,
  input  logic [XLEN-1:0]     dbg_pc_i,
  input  logic [DCAUSE_W-1:0] dbg_cause_i,
  input  logic                sw_we_i,
  input  logic [IDX_W-1:0]    sw_idx_i,
  input  logic [XLEN-1:0]     sw_wdata_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [XLEN-1:0]     rd_data_o,
  output logic                redirect_o,
  output logic [1:0]          vector_o
);

  localparam logic [ST_ILVL_W-1:0] DBG_L = ST_ILVL_W'(DBG_LVL);

  logic [1:0]                  rs_q;
  logic                        rst_core_n;
  logic                        commit;
  vec_e                        vec_sel;
  logic [NWP-1:0]              wp_en;
  logic [NWP-1:0][IDX_W-1:0]   wp_idx;
  logic [NWP-1:0][XLEN-1:0]    wp_data;
  logic [XLEN-1:0]             status_q;
  logic                        redir_q, redir_d;
  vec_e                        vec_q, vec_d;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_core_n = rs_q[1];

  exc_arbiter #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W),
    .DBG_LVL(DBG_LVL), .HAS_DEPC(HAS_DEPC), .IDX_W(IDX_W)
  ) u_arb (
    .status_i       (status_q),
    .exc_req_i      (exc_req_i),
    .exc_pc_i       (exc_pc_i),
    .exc_cause_i    (exc_cause_i),
    .exc_addr_vld_i (exc_addr_vld_i),
    .exc_addr_i     (exc_addr_i),
    .dbg_req_i      (dbg_req_i),
    .dbg_pc_i       (dbg_pc_i),
    .dbg_cause_i    (dbg_cause_i),
    .commit_o       (commit),
    .vec_o          (vec_sel),
    .wp_en_o        (wp_en),
    .wp_idx_o       (wp_idx),
    .wp_data_o      (wp_data)
  );

  exc_sreg_file #(.XLEN(XLEN), .NREG(NREG), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .commit_i   (commit),
    .wp_en_i    (wp_en),
    .wp_idx_i   (wp_idx),
    .wp_data_i  (wp_data),
    .sw_we_i    (sw_we_i),
    .sw_idx_i   (sw_idx_i),
    .sw_wdata_i (sw_wdata_i),
    .rd_idx_i   (rd_idx_i),
    .rd_data_o  (rd_data_o),
    .status_o   (status_q)
  );

  // redirect / vector next state
  always_comb begin
    redir_d = commit;
    vec_d   = commit ? vec_sel : vec_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      redir_q <= 1'b0;
      vec_q   <= VEC_KERNEL;
    end else begin
      redir_q <= redir_d;
      if (commit) begin
        vec_q <= vec_d;
      end
    end
  end

  assign redirect_o = redir_q;
  assign vector_o   = vec_q;

  p_double_vec_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (exc_req_i && status_q[ST_EXCM_BIT] &&
     (!dbg_req_i || status_q[ST_ILVL_W-1:0] >= DBG_L))
    |=> (redirect_o && vector_o == VEC_DOUBLE));

  p_excm_set_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    redirect_o |-> status_q[ST_EXCM_BIT]);

  p_dbg_blocked_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dbg_req_i && !exc_req_i && status_q[ST_ILVL_W-1:0] >= DBG_L)
    |=> !redirect_o);

  p_dbg_level_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (redirect_o && vector_o == VEC_DEBUG) |-> status_q[ST_ILVL_W-1:0] == DBG_L);

  p_dbg_first_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dbg_req_i && exc_req_i && status_q[ST_ILVL_W-1:0] < DBG_L)
    |=> (redirect_o && vector_o == VEC_DEBUG));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!exc_req_i && !dbg_req_i) |=> !redirect_o);

endmodule

// File: tb/tb_exc_dispatch.sv
`timescale 1ns/1ps
module tb_exc_dispatch;

  localparam int DBG  = 6;
  localparam int NR   = 24;
  localparam int IW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        e_req, e_av, d_req, s_we;
  logic [31:0] e_pc, e_addr, d_pc, s_data;
  logic [5:0]  e_cause, d_cause;
  logic [IW-1:0] s_idx, r_idx;
  logic [31:0] rd_a, rd_b;
  logic        redir_a, redir_b;
  logic [1:0]  vec_a, vec_b;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m [2][NR];

  exc_dispatch dut (
    .clk(clk), .rst_n(rst_n), .exc_req_i(e_req), .exc_pc_i(e_pc),
    .exc_cause_i(e_cause), .exc_addr_vld_i(e_av), .exc_addr_i(e_addr),
    .dbg_req_i(d_req), .dbg_pc_i(d_pc), .dbg_cause_i(d_cause),
    .sw_we_i(s_we), .sw_idx_i(s_idx), .sw_wdata_i(s_data),
    .rd_idx_i(r_idx), .rd_data_o(rd_a), .redirect_o(redir_a), .vector_o(vec_a));

  exc_dispatch #(.HAS_DEPC(1'b0)) dut_nodepc (
    .clk(clk), .rst_n(rst_n), .exc_req_i(e_req), .exc_pc_i(e_pc),
    .exc_cause_i(e_cause), .exc_addr_vld_i(e_av), .exc_addr_i(e_addr),
    .dbg_req_i(d_req), .dbg_pc_i(d_pc), .dbg_cause_i(d_cause),
    .sw_we_i(s_we), .sw_idx_i(s_idx), .sw_wdata_i(s_data),
    .rd_idx_i(r_idx), .rd_data_o(rd_b), .redirect_o(redir_b), .vector_o(vec_b));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    e_req = 0; e_av = 0; d_req = 0; s_we = 0;
    e_pc = 0; e_addr = 0; d_pc = 0; s_data = 0; e_cause = 0; d_cause = 0;
    s_idx = 0;
  endtask

  // model update for one instance; returns kind:
  // 0 idle, 1 sw, 2 refused debug, 3 debug, 4 normal fault, 5 double fault
  function automatic int model(input int k, input bit has_depc, output int vec);
    logic [31:0] st;
    int kind;
    st = m[k][0];
    vec = 0;
    kind = 0;
    if (d_req && st[3:0] < DBG) begin
      m[k][7+DBG]  = d_pc;
      m[k][16+DBG] = st;
      m[k][4]      = {26'd0, d_cause};
      m[k][0]      = {st[31:5], 1'b1, 4'(DBG)};
      vec = 3; kind = 3;
    end else if (e_req) begin
      if (st[4]) begin
        vec = 2; kind = 5;
        if (has_depc) m[k][3] = e_pc; else m[k][8] = e_pc;
      end else begin
        vec = st[5] ? 1 : 0; kind = 4;
        m[k][8] = e_pc;
      end
      m[k][1] = {26'd0, e_cause};
      if (e_av) m[k][2] = e_addr;
      m[k][0] = st | 32'h10;
    end else begin
      if (s_we && s_idx < NR) begin
        m[k][s_idx] = s_data;
        kind = 1;
      end
      if (d_req) kind = 2;
    end
    return kind;
  endfunction

  task automatic scan(input string req);
    int bad_a, bad_b;
    logic [31:0] av, ev, bv, fv;
    bad_a = -1; bad_b = -1;
    av = 0; ev = 0; bv = 0; fv = 0;
    for (int i = 0; i < NR; i++) begin
      r_idx = IW'(i);
      #0.1;
      if (rd_a !== m[0][i] && bad_a < 0) begin bad_a = i; av = rd_a; ev = m[0][i]; end
      if (rd_b !== m[1][i] && bad_b < 0) begin bad_b = i; bv = rd_b; fv = m[1][i]; end
    end
    chk(bad_a < 0, req, $sformatf("regs dut idx %0d", bad_a), av, ev);
    chk(bad_b < 0, req, $sformatf("regs dut_nodepc idx %0d", bad_b), bv, fv);
  endtask

  // inputs already set after a falling edge; commit and check
  task automatic step(input string note);
    int kind, kb, va, vb;
    string otag, rtag;
    kind = model(0, 1'b1, va);
    kb   = model(1, 1'b0, vb);
    case (kind)
      3: begin otag = "R7"; rtag = "R7"; end
      5: begin otag = "R1"; rtag = "R2 R4 R5"; end
      4: begin otag = "R3"; rtag = "R4 R5"; end
      2: begin otag = "R6"; rtag = "R6"; end
      1: begin otag = "R10"; rtag = "R9"; end
      default: begin otag = "R10"; rtag = "R10"; end
    endcase
    otag = {otag, note};
    rtag = {rtag, note};
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    if (kind >= 3) begin
      chk(redir_a === 1'b1 && vec_a === 2'(va), otag, "redirect/vector dut",
          {29'd0, redir_a, vec_a}, {29'd0, 1'b1, 2'(va)});
      chk(redir_b === 1'b1 && vec_b === 2'(vb), otag, "redirect/vector dut_nodepc",
          {29'd0, redir_b, vec_b}, {29'd0, 1'b1, 2'(vb)});
    end else begin
      chk(redir_a === 1'b0 && redir_b === 1'b0, otag, "no redirect",
          {30'd0, redir_a, redir_b}, 32'd0);
    end
    scan(rtag);
  endtask

  task automatic set_status(input logic [31:0] v);
    s_we = 1; s_idx = 0; s_data = v;
    step("");
  endtask

  initial begin
    #1600000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    r_idx = 0;
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < NR; i++) m[k][i] = 0;
    repeat (3) @(negedge clk);
    chk(redir_a === 1'b0, "R11", "redirect in reset", {31'd0, redir_a}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(redir_a === 1'b0 && redir_b === 1'b0, "R11", "redirect after reset",
        {30'd0, redir_a, redir_b}, 0);
    scan("R11");

    // user-mode fault with address
    set_status(32'h0000_0020);
    e_req = 1; e_pc = 32'h4000_1000; e_cause = 6'd9; e_av = 1; e_addr = 32'hDEAD_BEE0;
    step(" R5");
    // second fault while in exception mode: double
    e_req = 1; e_pc = 32'h4000_2000; e_cause = 6'd3; e_av = 0; e_addr = 32'h1111_1111;
    step(" R2 R5");
    // debug refused at the debug level
    set_status(32'h0000_0006);
    d_req = 1; d_pc = 32'h5000_0000; d_cause = 6'd1;
    step(" R6");
    // debug and fault together, debug wins
    set_status(32'h0000_0005);
    d_req = 1; d_pc = 32'h5000_0100; d_cause = 6'd2;
    e_req = 1; e_pc = 32'h6000_0000; e_cause = 6'd7; e_av = 1; e_addr = 32'h2222_2222;
    step(" R8");
    // software write dropped by a dispatch in the same cycle
    set_status(32'h0000_0000);
    e_req = 1; e_pc = 32'h7000_0000; e_cause = 6'd5;
    s_we = 1; s_idx = 5'd2; s_data = 32'hCAFE_F00D;
    step(" R9");
    // out-of-range read
    r_idx = 5'd30;
    #0.1;
    chk(rd_a === 32'd0, "R9", "out-of-range read", rd_a, 0);

    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 3) begin
        s_we = 1;
        s_idx = ($urandom_range(0, 3) == 0) ? IW'($urandom_range(0, 31)) : 5'd0;
        s_data = {$urandom() & 32'hFFFF_FFC0} | 32'($urandom_range(0, 1) << 5) |
                 32'($urandom_range(0, 9));
      end
      if (sel >= 3 && sel < 7) begin
        e_req = 1; e_pc = $urandom(); e_cause = 6'($urandom());
        e_av = 1'($urandom()); e_addr = $urandom();
      end
      if (sel >= 5 && sel < 9) begin
        d_req = 1; d_pc = $urandom(); d_cause = 6'($urandom());
      end
      if (sel >= 6 && sel < 8) begin
        s_we = 1; s_idx = IW'($urandom_range(0, 23)); s_data = $urandom();
      end
      step("");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule